// File: doc/BRIEF.md
# MDIO Station Management Command Engine

This block lets a processor manage an external Ethernet PHY without handling individual MDC/MDIO bit timing. Software writes a 16-bit data register and then a 16-bit control word. Writing the control word starts one management frame in the standard 22-register-address format. The frame is either a write of the data register to a PHY register or a read of a PHY register. When the frame ends, a finished bit in the control register goes high again. After a read, the data register holds the 16 bits that the PHY returned.

The management clock is divided down from the system clock. It runs only while a frame is in progress and stays low otherwise. While a frame is running, the engine ignores every register write. Software is expected to poll the finished bit before it issues a command and again until that command completes. A read from an address where no PHY answers leaves MDIO at its pulled-up level, so the returned value is 0xFFFF.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, the control register reads 0x8000 (finished set, all other bits zero), the data register reads 0x0000, and MDC and MDIO output-enable are both low.
- R2: Control word layout. Bit 13 set means write and clear means read. Bits 12:8 hold the PHY address and bits 4:0 the register address. On readback, bit 15 is the finished flag and bits 14 and 7:5 read as zero whatever was written.
- R3: A write command sends 64 MDC cycles with MDIO driven throughout. The bits are 32 ones, then 01, opcode 01, the PHY address and register address (each 5 bits, MSB first), turnaround 10, and then the data register MSB first.
- R4: A read command sends opcode 10. The engine drives MDIO for the first 46 bits (preamble, start, opcode, addresses) and releases it (output-enable low) for the 2 turnaround bits and the 16 data bits.
- R5: During a read, MDIO is sampled on each rising MDC edge of the data phase, MSB first. When finished sets, the data register holds the sampled word. If MDIO stays high because no PHY answers, the result is 0xFFFF.
- R6: An accepted control write clears the finished flag on the next clock. The flag sets again only after the last MDC cycle of the frame.
- R7: A control write while finished is clear changes neither the stored command fields nor the frame in flight, and starts no further frame.
- R8: A data register write while finished is clear leaves the data register unchanged.
- R9: Each MDC period is 2*MDC_HALF system clocks with a 50% duty cycle. MDC is held low whenever no frame is in progress.
- R10: MDIO output changes only on the falling MDC edge, so it is stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = engine drives) |
| mdio_i | input | 1 | MDIO input from the pad (pulled up when undriven) |

## Verification
The assertions assume two things about the inputs. First, software issues register writes through the single strobe and never leans on the timing of a write relative to an MDC edge. Second, mdio_i is meaningful only when the PHY drives it during the released phase. The stimulus issues every command only after the finished bit reads high. Its only writes during a running frame are the deliberate ones that probe R7 and R8. The PHY model drives mdio_i only after a falling MDC edge inside the released window and otherwise returns it to the pulled-up level. This keeps the sampling point, one half MDC period after the data change, well clear of any transition.

// File: rtl/mdio_cmd_pkg.sv
// Package: shared field positions and command type for the MDIO command engine.
// Assumes a 16-bit register port with one control and one data register.
package mdio_cmd_pkg;

    localparam int REG_W        = 16;
    localparam int ADDR_FIELD_W = 5;
    localparam int CTL_DONE_BIT = 15;
    localparam int CTL_OP_BIT   = 13;
    localparam int CTL_PHY_LSB  = 8;
    localparam int CTL_REG_LSB  = 0;

    localparam logic SEL_CTL  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef struct packed {
        logic                    is_write;
        logic [ADDR_FIELD_W-1:0] phy;
        logic [ADDR_FIELD_W-1:0] regad;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_div.sv
// Module: MDC divider. Produces a 50% duty management clock from clk while run is
// high, plus one-cycle tick pulses marking the clk edge at which MDC rises or falls.
// Assumes HALF >= 1; MDC is forced low and the counter cleared while run is low.
module mdio_mdc_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Terminal count of one half period
    assign wrap      = run && (cnt_q == CNT_LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: serial frame sequencer. On start it loads a full management frame and
// shifts it out MSB first, advancing one bit per falling MDC tick. For reads it
// releases MDIO from the turnaround onward and captures data on rising ticks.
// Assumes start is a one-cycle pulse issued only while idle.
module mdio_frame_seq
    import mdio_cmd_pkg::*;
#(
    parameter int PREAMBLE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  mdio_cmd_t        cmd,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rd_data,
    output logic             mdio_o,
    output logic             mdio_oe
);

    localparam int FRAME_BITS = PREAMBLE_BITS + 4 + 2 * ADDR_FIELD_W + 2 + REG_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = PREAMBLE_BITS + 4 + 2 * ADDR_FIELD_W;
    localparam int DATA_IDX   = TA_IDX + 2;
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_IDX);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] frame_d;
    logic [IDX_W-1:0]      bit_idx_q;
    logic                  is_rd_q;
    logic [REG_W-1:0]      cap_q;

    // Assemble the frame image for the pending command
    always_comb begin
        frame_d = {{PREAMBLE_BITS{1'b1}},
                   2'b01,
                   (cmd.is_write ? 2'b01 : 2'b10),
                   cmd.phy,
                   cmd.regad,
                   (cmd.is_write ? 2'b10 : 2'b11),
                   (cmd.is_write ? wr_data : {REG_W{1'b1}})};
    end

    // Bit sequencing, read capture and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_idx_q <= '0;
            busy      <= 1'b0;
            is_rd_q   <= 1'b0;
            cap_q     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                shift_q   <= frame_d;
                bit_idx_q <= '0;
                busy      <= 1'b1;
                is_rd_q   <= !cmd.is_write;
                cap_q     <= '0;
            end else if (busy) begin
                if (rise_tick && is_rd_q && (bit_idx_q >= IDX_DATA)) begin
                    cap_q <= {cap_q[REG_W-2:0], mdio_i};
                end
                if (fall_tick) begin
                    if (bit_idx_q == IDX_LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        shift_q   <= {shift_q[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_data = cap_q;
    assign mdio_o  = shift_q[FRAME_BITS-1];
    assign mdio_oe = busy && !(is_rd_q && (bit_idx_q >= IDX_TA));

endmodule

// File: rtl/mdio_cmd_regs.sv
// Module: register port and command decode. Holds the control fields, the
// finished flag and the data register; accepts writes only while finished is set
// and issues a start pulse one clock after an accepted control write.
// Assumes done is a one-cycle pulse from the sequencer.
module mdio_cmd_regs
    import mdio_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             done,
    input  logic [REG_W-1:0] rd_data,
    output mdio_cmd_t        cmd,
    output logic [REG_W-1:0] data_q,
    output logic             start,
    output logic             finished
);

    logic             accept;
    logic             data_wr;
    logic [REG_W-1:0] ctl_view;
    logic             unused_wbits;

    // Write qualification: ignore everything while a command runs
    assign accept  = reg_wr && (reg_addr == SEL_CTL) && finished;
    assign data_wr = reg_wr && (reg_addr == SEL_DATA) && finished;

    // Bits of the control word with no meaning
    assign unused_wbits = ^{reg_wdata[CTL_DONE_BIT:CTL_OP_BIT+1],
                            reg_wdata[CTL_PHY_LSB-1:CTL_REG_LSB+ADDR_FIELD_W]};

    // Command fields, finished flag and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd      <= '0;
            finished <= 1'b1;
            start    <= 1'b0;
        end else begin
            start <= accept;
            if (accept) begin
                cmd.is_write <= reg_wdata[CTL_OP_BIT];
                cmd.phy      <= reg_wdata[CTL_PHY_LSB +: ADDR_FIELD_W];
                cmd.regad    <= reg_wdata[CTL_REG_LSB +: ADDR_FIELD_W];
                finished     <= 1'b0;
            end else if (done) begin
                finished <= 1'b1;
            end
        end
    end

    // Data register: software load or read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= reg_wdata;
        end else if (done && !cmd.is_write) begin
            data_q <= rd_data;
        end
    end

    // Control readback view
    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_DONE_BIT]                      = finished;
        ctl_view[CTL_OP_BIT]                        = cmd.is_write;
        ctl_view[CTL_PHY_LSB +: ADDR_FIELD_W]       = cmd.phy;
        ctl_view[CTL_REG_LSB +: ADDR_FIELD_W]       = cmd.regad;
    end

    // Register read mux
    assign reg_rdata = (reg_addr == SEL_DATA) ? data_q : ctl_view;

endmodule

// File: rtl/mdio_cmd_engine.sv
// Module: top of the MDIO command engine. Ties the register port, the MDC
// divider and the frame sequencer together.
// Assumes MDIO is pulled up externally and mdio_i reflects the pad.
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF      = 4,
    parameter int PREAMBLE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    mdio_cmd_t        cmd;
    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] rd_data;
    logic             start;
    logic             finished;
    logic             busy;
    logic             done;
    logic             rise_tick;
    logic             fall_tick;

    mdio_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .done      (done),
        .rd_data   (rd_data),
        .cmd       (cmd),
        .data_q    (data_q),
        .start     (start),
        .finished  (finished)
    );

    mdio_mdc_div #(.HALF(MDC_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .wr_data   (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
// Module: property checker for the MDIO command engine, bound to the top.
// Counts rising MDC edges within a frame on its own to locate the released phase.
module mdio_cmd_engine_chk #(
    parameter int PREAMBLE_BITS = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        finished,
    input logic        is_write,
    input logic [4:0]  phy,
    input logic [4:0]  regad
);

    localparam int TA_IDX = PREAMBLE_BITS + 14;

    logic       mdc_q;
    logic [7:0] rises;

    // Track MDC history and count its rising edges within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
            rises <= '0;
        end else begin
            mdc_q <= mdc;
            if (!busy)
                rises <= '0;
            else if (mdc && !mdc_q)
                rises <= rises + 1'b1;
        end
    end

    assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_write && (int'(rises) > TA_IDX)) |-> !mdio_oe);

    assert_finish_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 1'b0) && finished) |=> !finished);

    assert_busy_ctl_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 1'b0) && !finished) |=>
            ($stable(is_write) && $stable(phy) && $stable(regad)));

    assert_mdc_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_mdio_stable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && mdc_q) |-> $stable(mdio_o));

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .finished (finished),
    .is_write (cmd.is_write),
    .phy      (cmd.phy),
    .regad    (cmd.regad)
);

// File: tb/mdio_cmd_engine_bench.sv
// Bench: scoreboard of expected frames fed by the command driver, checked by a
// PHY model that captures each frame on rising MDC and answers reads.
module mdio_cmd_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam logic [4:0] PHY_ADDR = 5'd5;
    localparam logic [63:0] MASK_WR = {64{1'b1}};
    localparam logic [63:0] MASK_RD = {{46{1'b1}}, {18{1'b0}}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_mdio = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] exp_frames[$];
    logic [63:0] exp_masks[$];
    logic [15:0] phy_mem[32];

    mdio_cmd_engine #(.MDC_HALF(HALF)) u_mdio_cmd_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (phy_mdio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl_word(input bit w, input logic [4:0] p,
                                             input logic [4:0] r);
        return {2'b00, w, p, 3'b000, r};
    endfunction

    function automatic logic [63:0] frame_of(input bit w, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
                (w ? 2'b10 : 2'b11), (w ? d : 16'hFFFF)};
    endfunction

    task automatic reg_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_read(1'b0, v);
            if (v[15]) return;
        end
        check(1'b0, tag, 64'(v), 64'h8000);
    endtask

    // Driver: push the expected frame, then issue the command
    task automatic issue(input bit w, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d);
        exp_frames.push_back(frame_of(w, p, r, d));
        exp_masks.push_back(w ? MASK_WR : MASK_RD);
        if (w) reg_write(1'b1, d);
        reg_write(1'b0, ctl_word(w, p, r));
    endtask

    // Monitor / PHY model
    int          rx_n = 0;
    logic [63:0] rx_bits = '0;
    logic [63:0] rx_oe = '0;
    logic        rx_rd = 1'b0;
    logic        rx_hit = 1'b0;
    logic [4:0]  rx_reg = '0;

    always @(posedge mdc) begin
        logic [63:0] ef, em;
        rx_bits = {rx_bits[62:0], mdio_o};
        rx_oe   = {rx_oe[62:0], mdio_oe};
        rx_n++;
        if (rx_n == 46) begin
            rx_rd  = (rx_bits[11:10] == 2'b10);
            rx_hit = (rx_bits[9:5] == PHY_ADDR);
            rx_reg = rx_bits[4:0];
        end
        if (rx_n == 64) begin
            if (exp_frames.size() == 0) begin
                check(1'b0, "R7 unexpected frame", rx_bits, 64'h0);
            end else begin
                ef = exp_frames.pop_front();
                em = exp_masks.pop_front();
                check((rx_bits & em) == (ef & em), "R3/R4 frame bits", rx_bits & em, ef & em);
                check(rx_oe == em, "R3/R4 output enable", rx_oe, em);
            end
            if (!rx_rd && rx_hit) phy_mem[rx_reg] = rx_bits[15:0];
            rx_n = 0;
        end
    end

    always @(negedge mdc) begin
        if (rx_rd && rx_hit && rx_n == 47)
            phy_mdio = 1'b0;
        else if (rx_rd && rx_hit && rx_n >= 48 && rx_n < 64)
            phy_mdio = phy_mem[rx_reg][63 - rx_n];
        else
            phy_mdio = 1'b1;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // MDC period measurement on the first frame (R9)
    initial begin
        int t1;
        @(posedge mdc);
        t1 = cyc;
        @(posedge mdc);
        check((cyc - t1) == 2 * HALF, "R9 mdc period", 64'(cyc - t1), 64'(2 * HALF));
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'hC000 | (16'(i) * 16'h0101);
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        reg_read(1'b0, v);
        check(v == 16'h8000, "R1 ctl reset", 64'(v), 64'h8000);
        reg_read(1'b1, v);
        check(v == 16'h0000, "R1 data reset", 64'(v), 64'h0);
        check(mdc == 1'b0, "R1 mdc low", 64'(mdc), 64'h0);
        check(mdio_oe == 1'b0, "R1 oe low", 64'(mdio_oe), 64'h0);

        // R3/R6 write 0x1234 to phy 5 reg 3
        issue(1'b1, PHY_ADDR, 5'd3, 16'h1234);
        reg_read(1'b0, v);
        check(v == 16'h2503, "R6 finished cleared / R2 fields", 64'(v), 64'h2503);
        wait_done("R6 write finish");
        reg_read(1'b0, v);
        check(v == 16'hA503, "R6 finished set", 64'(v), 64'hA503);

        // R5 read back
        issue(1'b0, PHY_ADDR, 5'd3, 16'h0);
        wait_done("R5 read finish");
        reg_read(1'b1, v);
        check(v == 16'h1234, "R5 read value", 64'(v), 64'h1234);

        issue(1'b0, PHY_ADDR, 5'd31, 16'h0);
        wait_done("R5 read finish");
        reg_read(1'b1, v);
        check(v == 16'hDF1F, "R5 read reg31", 64'(v), 64'hDF1F);

        // R5 absent PHY
        issue(1'b0, 5'd9, 5'd2, 16'h0);
        wait_done("R5 absent finish");
        reg_read(1'b1, v);
        check(v == 16'hFFFF, "R5 absent phy", 64'(v), 64'hFFFF);

        // R7 control write while busy
        issue(1'b0, PHY_ADDR, 5'd7, 16'h0);
        repeat (100) @(posedge clk);
        reg_write(1'b0, ctl_word(1'b1, 5'd9, 5'd1));
        reg_read(1'b0, v);
        check(v == 16'h0507, "R7 fields kept", 64'(v), 64'h0507);
        wait_done("R7 finish");
        reg_read(1'b1, v);
        check(v == 16'hC707, "R7 read intact", 64'(v), 64'hC707);
        repeat (200) @(negedge clk);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 no extra frame", 64'({mdc, mdio_oe}), 64'h0);
        check(exp_frames.size() == 0, "R7 scoreboard drained", 64'(exp_frames.size()), 64'h0);

        // R8 data write while busy
        issue(1'b1, PHY_ADDR, 5'd10, 16'hBEEF);
        repeat (100) @(posedge clk);
        reg_write(1'b1, 16'h0000);
        reg_read(1'b1, v);
        check(v == 16'hBEEF, "R8 data kept busy", 64'(v), 64'hBEEF);
        wait_done("R8 finish");
        reg_read(1'b1, v);
        check(v == 16'hBEEF, "R8 data kept after", 64'(v), 64'hBEEF);
        issue(1'b0, PHY_ADDR, 5'd10, 16'h0);
        wait_done("R8 read finish");
        reg_read(1'b1, v);
        check(v == 16'hBEEF, "R8 phy got original", 64'(v), 64'hBEEF);

        // R3 bit order with end bits set
        issue(1'b1, PHY_ADDR, 5'd0, 16'h8001);
        wait_done("R3 finish");
        issue(1'b0, PHY_ADDR, 5'd0, 16'h0);
        wait_done("R3 read finish");
        reg_read(1'b1, v);
        check(v == 16'h8001, "R3 msb first", 64'(v), 64'h8001);

        // R2 spare bits read zero
        exp_frames.push_back(frame_of(1'b1, 5'd31, 5'd31, 16'h8001));
        exp_masks.push_back(MASK_WR);
        reg_write(1'b0, 16'hFFFF);
        reg_read(1'b0, v);
        check(v == 16'h3F1F, "R2 spare bits zero", 64'(v), 64'h3F1F);
        wait_done("R2 finish");
        repeat (20) @(negedge clk);
        check(exp_frames.size() == 0, "R3 all frames seen", 64'(exp_frames.size()), 64'h0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule